// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block is the host side of a slave-serial configuration link. When `start` is pulsed it resets the target device. It drives the active-low program line low and waits for the target's active-low init line to answer low. It then releases the program line and waits for the init line to come back high. After an optional wait it streams bitstream bytes into the target one bit at a time on a data line, qualified by a configuration clock that the block generates itself.

Bytes come from a supplier through a valid/ready byte port, and the supplier marks the final byte. The configuration clock may stop, held low, whenever no byte is waiting, so a slow supplier only stretches the load. After the final byte the block keeps the clock running with the data line high and watches the target's done line. It ends the session as finished, as a timeout or, if the init line drops while data is moving, as a configuration error. A bit-order option serves files whose bytes were stored reversed.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and while idle, `busy`=0, `prog_b`=1, `cclk`=0, `din`=1 and `byte_ready`=0. A `start` pulse seen while idle drives `prog_b` low from the next clock. `prog_b` stays low for as long as `init_b` is high, and `cclk` never rises while `prog_b` is low.
- R2: `prog_b` returns high one clock after `init_b` is seen low. No byte is requested and `cclk` stays low until `init_b` is seen high again.
- R3: `byte_ready` first asserts exactly `init_delay`+1 clocks after `init_b` is driven high. With `init_delay`=0 that is the clock edge that first sees `init_b` high.
- R4: `din` is stable on every clock where `cclk` rises and during every clock where `cclk` stays high, so it changes only while `cclk` is low or as `cclk` falls. Each high phase of `cclk` lasts exactly `HALF_DIV` clocks, and each low phase lasts at least `HALF_DIV` clocks.
- R5: While `byte_ready`=1, `cclk` is low and `byte_valid`=0, `cclk` stays low on the next clock. The link pauses instead of running on without data.
- R6: With `swap_bits`=0 each byte goes out bit 7 first. With `swap_bits`=1 it goes out bit 0 first. A stream of 0xFF padding bytes followed by 0xAA,0x99,0x55,0x66 therefore shows the sync word 0xAA995566 on the line.
- R7: After the bit 0/7 of the byte marked `byte_last` has been shifted, `cclk` keeps toggling with `din`=1. `load_ok` sets on the falling edge of `cclk` that completes max(`EXTRA_CYC`, D) extra rising edges, where `done_in` is high by rising edge D.
- R8: If `done_in` is not high when `DONE_LIMIT` extra rising edges have completed, the session ends with `timeout`=1. A done seen exactly at the limit still gives `load_ok`.
- R9: If `init_b` is low while bits or trailing clocks are being sent, one clock later `busy`=0, `init_err`=1, `cclk`=0 and `prog_b`=1.
- R10: At most one of `load_ok`, `init_err` and `timeout` is set. It holds until the next `start`, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load session (only acted on while idle) |
| swap_bits | input | 1 | 1: shift each byte bit 0 first |
| init_delay | input | DLY_W | Clocks to wait after init_b rises before the first bit |
| byte_data | input | 8 | Bitstream byte |
| byte_valid | input | 1 | byte_data holds a byte |
| byte_last | input | 1 | Current byte is the final one |
| byte_ready | output | 1 | Loader accepts the byte on this clock |
| prog_b | output | 1 | Active-low program line to the target |
| cclk | output | 1 | Configuration clock to the target |
| din | output | 1 | Serial configuration data |
| init_b | input | 1 | Target init line (low: clearing or error) |
| done_in | input | 1 | Target done line |
| busy | output | 1 | A session is in progress |
| load_ok | output | 1 | Last session finished with done high |
| init_err | output | 1 | Last session aborted on init low |
| timeout | output | 1 | Last session ran out of trailing clocks |

## Verification
Every result has a fixed latency. The program line falls on the clock after `start` and rises on the clock after `init_b` is seen low. The first byte request comes `init_delay`+1 clocks after `init_b` rises. An abort shows on the clock after `init_b` drops. The bench drives inputs on the falling system-clock edge and samples one falling edge later, so each count matches those register stages. Results tied to the configuration clock are counted in `cclk` rising edges rather than system clocks, because supplier stalls stretch the low phases. The bench captures `din` at each rising `cclk` and checks the trailing-edge count once the session status appears.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    localparam int BYTE_W = 8;
    localparam int LEFT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PROG,
        LD_WAIT_HI,
        LD_DELAY,
        LD_SHIFT,
        LD_FLUSH
    } ld_state_t;

    typedef struct packed {
        logic ok;
        logic init_err;
        logic timeout;
    } ld_status_t;

    // Present a byte so that its first-sent bit sits at the top.
    function automatic logic [BYTE_W-1:0] order_byte(input logic [BYTE_W-1:0] b,
                                                     input logic swap);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return swap ? r : b;
    endfunction

endpackage

// File: rtl/cfgld_halfper.sv
module cfgld_halfper #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cfgld_serializer.sv
module cfgld_serializer
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              load_last,
    input  logic              swap,
    input  logic              advance,
    output logic              din,
    output logic              have_bit,
    output logic              final_bit,
    output logic              cur_last
);
    logic [BYTE_W-1:0] sreg;
    logic [LEFT_W-1:0] left;
    logic [BYTE_W-1:0] ordered;

    assign ordered   = order_byte(load_byte, swap);
    assign have_bit  = (left != '0);
    assign final_bit = (left == LEFT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sreg     <= '0;
            left     <= '0;
            cur_last <= 1'b0;
            din      <= 1'b1;
        end else if (load) begin
            sreg     <= ordered;
            din      <= ordered[BYTE_W-1];
            left     <= LEFT_W'(BYTE_W);
            cur_last <= load_last;
        end else if (advance) begin
            if (left > LEFT_W'(1)) begin
                sreg <= {sreg[BYTE_W-2:0], 1'b0};
                din  <= sreg[BYTE_W-2];
                left <= left - 1'b1;
            end else begin
                left <= '0;
                din  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter int DLY_W      = 16,
    parameter int EXTRA_CYC  = 16,
    parameter int DONE_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             init_b,
    input  logic             done_in,
    input  logic [DLY_W-1:0] init_delay,
    input  logic             byte_valid,
    input  logic             have_bit,
    input  logic             final_bit,
    input  logic             cur_last,
    input  logic             tick,
    output logic             prog_b,
    output logic             cclk,
    output logic             byte_ready,
    output logic             load,
    output logic             advance,
    output logic             ser_clear,
    output logic             run,
    output logic             busy,
    output ld_status_t       status
);
    localparam int FCW = $clog2(DONE_LIMIT + 1);

    ld_state_t        st;
    logic [DLY_W-1:0] dcnt;
    logic [FCW-1:0]   fcnt;
    logic [FCW-1:0]   fnext;
    logic             done_seen;
    logic             streaming, abort, rise, fall, done_hit;

    always_comb begin
        streaming  = (st == LD_SHIFT) || (st == LD_FLUSH);
        abort      = streaming && !init_b;
        run        = ((st == LD_SHIFT) && have_bit) || (st == LD_FLUSH);
        rise       = run && !cclk && tick;
        fall       = run && cclk && tick;
        byte_ready = (st == LD_SHIFT) &&
                     (!have_bit || (fall && final_bit && !cur_last));
        load       = byte_ready && byte_valid;
        advance    = fall && (st == LD_SHIFT);
        ser_clear  = (st == LD_IDLE) || abort;
        fnext      = fcnt + 1'b1;
        done_hit   = done_seen || done_in;
        busy       = (st != LD_IDLE);
        prog_b     = (st != LD_PROG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= LD_IDLE;
            cclk      <= 1'b0;
            dcnt      <= '0;
            fcnt      <= '0;
            done_seen <= 1'b0;
            status    <= '0;
        end else begin
            if (busy && done_in) done_seen <= 1'b1;
            if (abort) begin
                st              <= LD_IDLE;
                cclk            <= 1'b0;
                status.init_err <= 1'b1;
            end else begin
                unique case (st)
                    LD_IDLE: if (start) begin
                        st        <= LD_PROG;
                        status    <= '0;
                        done_seen <= 1'b0;
                    end
                    LD_PROG: if (!init_b) st <= LD_WAIT_HI;
                    LD_WAIT_HI: if (init_b) begin
                        if (init_delay == '0) st <= LD_SHIFT;
                        else begin
                            st   <= LD_DELAY;
                            dcnt <= init_delay - 1'b1;
                        end
                    end
                    LD_DELAY: begin
                        if (dcnt == '0) st <= LD_SHIFT;
                        else            dcnt <= dcnt - 1'b1;
                    end
                    LD_SHIFT: begin
                        if (rise) cclk <= 1'b1;
                        if (fall) begin
                            cclk <= 1'b0;
                            if (final_bit && cur_last) begin
                                st   <= LD_FLUSH;
                                fcnt <= '0;
                            end
                        end
                    end
                    LD_FLUSH: begin
                        if (rise) cclk <= 1'b1;
                        if (fall) begin
                            cclk <= 1'b0;
                            fcnt <= fnext;
                            if (done_hit && fnext >= FCW'(EXTRA_CYC)) begin
                                st        <= LD_IDLE;
                                status.ok <= 1'b1;
                            end else if (fnext >= FCW'(DONE_LIMIT)) begin
                                st             <= LD_IDLE;
                                status.timeout <= 1'b1;
                            end
                        end
                    end
                    default: st <= LD_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgld_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int DLY_W      = 16,
    parameter int EXTRA_CYC  = 16,
    parameter int DONE_LIMIT = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             swap_bits,
    input  logic [DLY_W-1:0] init_delay,
    input  logic [7:0]       byte_data,
    input  logic             byte_valid,
    input  logic             byte_last,
    output logic             byte_ready,
    output logic             prog_b,
    output logic             cclk,
    output logic             din,
    input  logic             init_b,
    input  logic             done_in,
    output logic             busy,
    output logic             load_ok,
    output logic             init_err,
    output logic             timeout
);
    logic       tick, run, load, advance, ser_clear;
    logic       have_bit, final_bit, cur_last;
    ld_status_t status;

    cfgld_halfper #(.HALF_DIV(HALF_DIV)) u_half (
        .clk (clk),
        .rst (rst),
        .run (run),
        .tick(tick)
    );

    cfgld_serializer u_ser (
        .clk      (clk),
        .rst      (rst),
        .clear    (ser_clear),
        .load     (load),
        .load_byte(byte_data),
        .load_last(byte_last),
        .swap     (swap_bits),
        .advance  (advance),
        .din      (din),
        .have_bit (have_bit),
        .final_bit(final_bit),
        .cur_last (cur_last)
    );

    cfgld_seq #(
        .DLY_W     (DLY_W),
        .EXTRA_CYC (EXTRA_CYC),
        .DONE_LIMIT(DONE_LIMIT)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .init_b    (init_b),
        .done_in   (done_in),
        .init_delay(init_delay),
        .byte_valid(byte_valid),
        .have_bit  (have_bit),
        .final_bit (final_bit),
        .cur_last  (cur_last),
        .tick      (tick),
        .prog_b    (prog_b),
        .cclk      (cclk),
        .byte_ready(byte_ready),
        .load      (load),
        .advance   (advance),
        .ser_clear (ser_clear),
        .run       (run),
        .busy      (busy),
        .status    (status)
    );

    assign load_ok  = status.ok;
    assign init_err = status.init_err;
    assign timeout  = status.timeout;
endmodule

// File: rtl/cfgld_checks.sv
module cfgld_checks (
    input logic clk,
    input logic rst,
    input logic cclk,
    input logic din,
    input logic prog_b,
    input logic init_b,
    input logic byte_ready,
    input logic byte_valid,
    input logic busy,
    input logic load_ok,
    input logic init_err,
    input logic timeout
);
    AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        !prog_b |-> !cclk);                                               // R1
    AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!prog_b && init_b) |=> !prog_b);                                 // R1
    AST_PROG_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!prog_b && !init_b) |=> prog_b);                                 // R2
    AST_DIN_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(din));                                    // R4
    AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cclk && $past(cclk)) |-> $stable(din));                          // R4
    AST_PAUSE_LOW: assert property (@(posedge clk) disable iff (rst)
        (byte_ready && !byte_valid && !cclk) |=> !cclk);                  // R5
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(init_err) |-> (!busy && !cclk && prog_b));                  // R9
    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $countones({load_ok, init_err, timeout}) <= 1);                   // R10
endmodule

bind cfg_serial_loader cfgld_checks u_chk (.*);

// File: tb/sim_cfg_serial_loader.sv
`timescale 1ns/1ps
module sim_cfg_serial_loader;
    localparam int HALF  = 2;
    localparam int DW    = 8;
    localparam int EXTRA = 8;
    localparam int LIMIT = 20;

    logic clk = 0, rst = 1, start = 0, swap_bits = 0;
    logic [DW-1:0] init_delay = '0;
    logic [7:0] byte_data = '0;
    logic byte_valid = 0, byte_last = 0;
    logic byte_ready, prog_b, cclk, din, busy, load_ok, init_err, timeout;
    logic tgt_init = 1, err_pull = 0, done_in = 0;
    wire  init_b = tgt_init & ~err_pull;

    cfg_serial_loader #(.HALF_DIV(HALF), .DLY_W(DW), .EXTRA_CYC(EXTRA),
                        .DONE_LIMIT(LIMIT)) u0 (.*);

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int sess = 0, seen_sess = 0, exp_bits = 0, done_plan = -1, err_at = -1;
    int hi_len = 0;
    bit err_chk = 0;
    bit cap[$];
    logic p_cclk = 0, p_din = 1, p_ready = 0, p_valid = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] flip(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    // per-clock reference of the line rules and the behavioural target
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
        if (sess != seen_sess) begin
            seen_sess = sess; cap.delete(); done_in = 0; err_pull = 0;
            hi_len = 0; err_chk = 0;
        end
        if (!rst) begin
            chk(!(cclk && !prog_b), "R1", "cclk while prog_b low", cclk, 0);
            if (cclk) chk(din == p_din, "R4", "din moved near/within high", din, p_din);
            chk(!(p_ready && !p_valid && !p_cclk && cclk), "R5",
                "cclk rose without data", cclk, 0);
            if (err_chk) begin
                chk(busy == 0 && init_err == 1 && cclk == 0 && prog_b == 1, "R9",
                    "abort state {busy,err,cclk,prog}",
                    {busy, init_err, cclk, prog_b}, 4'b0101);
                err_chk = 0;
            end
            if (cclk) hi_len++;
            else begin
                if (p_cclk && !err_pull) chk(hi_len == HALF, "R4", "high length", hi_len, HALF);
                hi_len = 0;
            end
            if (!p_cclk && cclk) cap.push_back(din);
            if (err_at >= 0 && !err_pull && cap.size() == err_at) begin
                err_pull = 1; err_chk = 1;
            end
            if (done_plan >= 0 && exp_bits > 0 && cap.size() >= exp_bits + done_plan)
                done_in = 1;
        end
        p_cclk = cclk; p_din = din; p_ready = byte_ready; p_valid = byte_valid;
    end

    task automatic run_session(input logic [7:0] pay[$], input bit swp, input int dly,
                               input int dplan, input int eat, input int gap);
        int k, extra, exp_extra;
        bit all_one;
        logic [7:0] got;
        sess++; swap_bits = swp; init_delay = DW'(dly);
        done_plan = dplan; err_at = eat; exp_bits = pay.size() * 8;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(busy && !prog_b, "R1", "prog_b low after start", {busy, prog_b}, 2'b10);
        chk({load_ok, init_err, timeout} == 0, "R10", "status cleared by start",
            {load_ok, init_err, timeout}, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!prog_b, "R1", "prog_b held while init_b high", prog_b, 0);
        end
        tgt_init = 0;
        @(negedge clk);
        chk(prog_b, "R2", "prog_b released after init_b low", prog_b, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!cclk && !byte_ready, "R2", "idle before init_b high",
                {cclk, byte_ready}, 0);
        end
        tgt_init = 1;
        k = 0;
        do begin @(negedge clk); k++; end while (!byte_ready && k < 300);
        chk(k == dly + 1, "R3", "clocks to first request", k, dly + 1);
        for (int i = 0; i < pay.size(); i++) begin
            byte_valid = 1; byte_data = pay[i]; byte_last = (i == pay.size() - 1);
            while (!byte_ready && busy) @(negedge clk);
            if (!busy) break;
            @(negedge clk);
            byte_valid = 0; byte_last = 0;
            if (gap > 0 && (i % 3) == 1) repeat (gap) @(negedge clk);
        end
        byte_valid = 0; byte_last = 0;
        k = 0;
        while (busy && k < 5000) begin @(negedge clk); k++; end
        if (eat >= 0) begin
            chk(init_err && !load_ok && !timeout, "R9", "error status",
                {load_ok, init_err, timeout}, 3'b010);
            chk(cap.size() == eat, "R9", "bits before abort", cap.size(), eat);
        end else begin
            for (int b = 0; b < pay.size(); b++) begin
                for (int j = 0; j < 8; j++) got[7-j] = cap[b*8+j];
                chk(got == (swp ? flip(pay[b]) : pay[b]), "R6", "captured byte",
                    got, swp ? flip(pay[b]) : pay[b]);
            end
            for (int b = 0; b < 4; b++) begin
                for (int j = 0; j < 8; j++) got[7-j] = cap[(4+b)*8+j];
                chk(got == 8'(32'hAA995566 >> (24 - 8*b)), "R6", "sync byte on line",
                    got, 8'(32'hAA995566 >> (24 - 8*b)));
            end
            extra = cap.size() - exp_bits;
            all_one = 1;
            for (int j = exp_bits; j < cap.size(); j++) if (!cap[j]) all_one = 0;
            chk(all_one, "R7", "din high in trailing clocks", all_one, 1);
            if (dplan >= 0 && ((dplan > EXTRA) ? dplan : EXTRA) <= LIMIT) begin
                exp_extra = (dplan > EXTRA) ? dplan : EXTRA;
                chk(load_ok && !timeout, "R7", "load_ok", {load_ok, timeout}, 2'b10);
                chk(extra == exp_extra, "R7", "trailing edges", extra, exp_extra);
            end else begin
                chk(timeout && !load_ok, "R8", "timeout", {load_ok, timeout}, 2'b01);
                chk(extra == LIMIT, "R8", "edges at timeout", extra, LIMIT);
            end
        end
        repeat (5) @(negedge clk);
        chk($countones({load_ok, init_err, timeout}) == 1, "R10", "status held",
            {load_ok, init_err, timeout}, 1);
    endtask

    initial begin
        logic [7:0] s[$];
        logic [7:0] r[$];
        s = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h99, 8'h55, 8'h66,
              8'h30, 8'hA1, 8'h00, 8'h07};
        foreach (s[i]) r.push_back(flip(s[i]));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({busy, prog_b, cclk, din, byte_ready} == 5'b01010, "R1", "reset state",
            {busy, prog_b, cclk, din, byte_ready}, 5'b01010);
        chk({load_ok, init_err, timeout} == 0, "R10", "reset status",
            {load_ok, init_err, timeout}, 0);
        run_session(s, 0, 0, 0, -1, 0);    // R3 zero delay, R7 minimum trailing
        run_session(r, 1, 5, 12, -1, 5);   // R6 swapped order, R5 stalls
        run_session(s, 0, 1, LIMIT, -1, 0);  // R8 done exactly at limit
        run_session(s, 0, 2, -1, -1, 3);   // R8 done never
        run_session(s, 0, 0, LIMIT + 1, -1, 0); // R8 done one past limit
        run_session(s, 0, 3, 0, 20, 0);    // R9 init low mid-stream
        run_session(s, 0, 0, 3, -1, 2);    // R10 clean run after error
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule